// File: doc/BRIEF.md
# Single-Frame Loopback Clock-Domain Bridge

This block moves one looped-back frame of nibble data from the clock of the arriving side to the clock of the departing side. It removes any need to switch or gate a clock for debug loopback. The arriving side presents a 4-bit nibble with a valid strobe in its own clock domain. The block stores the frame in a small dual-clock buffer. Once the whole frame is stored, it replays the frame in the departing clock domain as a continuous valid burst with the same nibbles in the same order.

Only one frame is held at a time. Throughput is not a goal on a debug path, so any frame that begins while the buffer is still occupied is discarded whole. Each side tells the other about its events with a toggle that crosses through a two-flip-flop synchronizer:
- The write side toggles when a complete frame is in the buffer.
- The read side toggles when it has finished the replay. Only then does the write side free the buffer.

A frame longer than the buffer is cut at capacity. The part that was stored is still replayed, and an overflow bit is raised in the write domain.

Top module: `lbk_bridge`

## Requirements
- R1: After reset of both domains, `rd_dv_o` and `wr_ovf_o` are 0, and no nibble is replayed until a complete frame has been written.
- R2: A frame is a run of cycles with `wr_dv_i` high and ends on the cycle where `wr_dv_i` is low again. It is replayed as exactly one run of `rd_dv_o` high whose length equals the number of nibbles written. The run has no gaps, and `rd_data_o` carries the written nibbles in arrival order.
- R3: A frame that starts while an earlier frame is stored and not yet fully replayed is dropped entirely. None of its nibbles is ever replayed.
- R4: Replay begins only after the frame-complete event has passed two flip-flop stages in the read clock domain. `rd_dv_o` therefore rises no sooner than two read clock periods after `wr_dv_i` fell.
- R5: After the replay of a frame ends and the completion event has crossed back to the write domain, a new frame is accepted and replayed.
- R6: A frame longer than the buffer depth `DEPTH` is truncated: exactly its first `DEPTH` nibbles are replayed. `wr_ovf_o` goes to 1 and stays there until the next accepted frame starts, when it returns to 0. A frame of at most `DEPTH` nibbles leaves `wr_ovf_o` at 0.
- R7: Between replays, `rd_dv_o` stays 0 while no new frame is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk_i | input | 1 | Clock of the arriving side |
| wr_rst_ni | input | 1 | Active-low asynchronous reset, write domain |
| wr_dv_i | input | 1 | Nibble valid, arriving side |
| wr_data_i | input | 4 | Nibble data, arriving side |
| wr_ovf_o | output | 1 | Last accepted frame was truncated (write domain) |
| rd_clk_i | input | 1 | Clock of the departing side |
| rd_rst_ni | input | 1 | Active-low asynchronous reset, read domain |
| rd_dv_o | output | 1 | Nibble valid, departing side |
| rd_data_o | output | 4 | Nibble data, departing side |

## Verification
The embedded assertions check the following on every cycle:
- no buffer write happens while a stored frame is pending;
- the write pointer never passes the buffer depth;
- a stored length is always between 1 and the depth;
- the read pointer stays inside the stored length;
- the overflow flag holds until a new frame starts;
- every replay burst opens at the first buffer slot.

The directed scenarios are needed for the behaviour that spans both clocks. These are the nibble-for-nibble content and length of each replay, the delay between the end of a frame and the first replayed nibble, the full discard of a frame that overlaps a pending one, the release of the buffer after a replay, and the content replayed after truncation.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
  typedef logic [3:0] nib_t;
  typedef enum logic {RD_IDLE, RD_PLAY} rd_state_e;
endpackage

// File: rtl/lbk_sync.sv
module lbk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lbk_mem.sv
module lbk_mem
  import lbk_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  nib_t          wdata_i,
  input  logic [AW-1:0] raddr_i,
  output nib_t          rdata_o
);
  nib_t mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // Read side only addresses entries written before the frame-complete toggle
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/lbk_wr_ctrl.sv
module lbk_wr_ctrl
  import lbk_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dv_i,
  input  nib_t          data_i,
  input  logic          done_tgl_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output nib_t          wdata_o,
  output logic          full_tgl_o,
  output logic [CW-1:0] len_o,
  output logic          ovf_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic          dv_q, done_q, acc_q, occ_q, ovf_q, full_tgl_q;
  logic [CW-1:0] ptr_q, len_q, wr_idx;
  logic          sof, eof, done_evt, acc_now;

  assign sof      = dv_i & ~dv_q;
  assign eof      = ~dv_i & dv_q;
  assign done_evt = done_tgl_i ^ done_q;
  assign acc_now  = sof ? ~occ_q : acc_q;
  assign wr_idx   = sof ? '0 : ptr_q;

  assign we_o    = dv_i & acc_now & (wr_idx < DEPTH_C);
  assign waddr_o = wr_idx[AW-1:0];
  assign wdata_o = data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dv_q       <= 1'b0;
      done_q     <= 1'b0;
      acc_q      <= 1'b0;
      occ_q      <= 1'b0;
      ovf_q      <= 1'b0;
      full_tgl_q <= 1'b0;
      ptr_q      <= '0;
      len_q      <= '0;
    end else begin
      dv_q   <= dv_i;
      done_q <= done_tgl_i;
      if (done_evt) occ_q <= 1'b0;
      if (sof && !occ_q) begin
        acc_q <= 1'b1;
        ptr_q <= CW'(1);
        ovf_q <= 1'b0;
      end else if (acc_q && dv_i) begin
        if (ptr_q < DEPTH_C) ptr_q <= ptr_q + CW'(1);
        else                 ovf_q <= 1'b1;
      end
      if (eof && acc_q) begin
        acc_q      <= 1'b0;
        occ_q      <= 1'b1;
        len_q      <= ptr_q;
        full_tgl_q <= ~full_tgl_q;
      end
    end
  end

  assign full_tgl_o = full_tgl_q;
  assign len_o      = len_q;
  assign ovf_o      = ovf_q;

  AST_NO_WRITE_WHILE_OCC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q |-> !we_o); // R3
  AST_PTR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= DEPTH_C); // R6
  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q |-> (len_q != '0 && len_q <= DEPTH_C)); // R2
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !sof) |=> ovf_q); // R6
endmodule

// File: rtl/lbk_rd_ctrl.sv
module lbk_rd_ctrl
  import lbk_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          full_tgl_i,
  input  logic [CW-1:0] len_i,
  input  nib_t          rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic          done_tgl_o,
  output logic          dv_o,
  output nib_t          data_o
);
  rd_state_e     state_q;
  logic          tgl_q, done_tgl_q, dv_q;
  logic [CW-1:0] ptr_q, rlen_q;
  nib_t          data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RD_IDLE;
      tgl_q      <= 1'b0;
      done_tgl_q <= 1'b0;
      dv_q       <= 1'b0;
      ptr_q      <= '0;
      rlen_q     <= '0;
      data_q     <= '0;
    end else begin
      unique case (state_q)
        RD_IDLE: begin
          dv_q <= 1'b0;
          if (full_tgl_i != tgl_q) begin
            tgl_q   <= full_tgl_i;
            ptr_q   <= '0;
            rlen_q  <= len_i;
            state_q <= RD_PLAY;
          end
        end
        RD_PLAY: begin
          dv_q   <= 1'b1;
          data_q <= rdata_i;
          if (ptr_q == rlen_q - CW'(1)) begin
            done_tgl_q <= ~done_tgl_q;
            state_q    <= RD_IDLE;
          end else begin
            ptr_q <= ptr_q + CW'(1);
          end
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  assign raddr_o    = ptr_q[AW-1:0];
  assign done_tgl_o = done_tgl_q;
  assign dv_o       = dv_q;
  assign data_o     = data_q;

  AST_RD_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RD_PLAY) |-> (ptr_q < rlen_q)); // R2
  AST_BURST_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dv_q) |-> ($past(ptr_q) == '0)); // R4
endmodule

// File: rtl/lbk_bridge.sv
module lbk_bridge
  import lbk_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       wr_clk_i,
  input  logic       wr_rst_ni,
  input  logic       wr_dv_i,
  input  logic [3:0] wr_data_i,
  output logic       wr_ovf_o,
  input  logic       rd_clk_i,
  input  logic       rd_rst_ni,
  output logic       rd_dv_o,
  output logic [3:0] rd_data_o
);
  logic          we, full_tgl, full_tgl_s, done_tgl, done_tgl_s;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] len;
  nib_t          wdata, rdata;

  lbk_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk_i      (wr_clk_i),
    .rst_ni     (wr_rst_ni),
    .dv_i       (wr_dv_i),
    .data_i     (wr_data_i),
    .done_tgl_i (done_tgl_s),
    .we_o       (we),
    .waddr_o    (waddr),
    .wdata_o    (wdata),
    .full_tgl_o (full_tgl),
    .len_o      (len),
    .ovf_o      (wr_ovf_o)
  );

  lbk_mem #(.DEPTH(DEPTH)) u_mem (
    .wclk_i  (wr_clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  lbk_sync #(.STAGES(SYNC_STAGES)) u_sync_full (
    .clk_i  (rd_clk_i),
    .rst_ni (rd_rst_ni),
    .d_i    (full_tgl),
    .q_o    (full_tgl_s)
  );

  lbk_sync #(.STAGES(SYNC_STAGES)) u_sync_done (
    .clk_i  (wr_clk_i),
    .rst_ni (wr_rst_ni),
    .d_i    (done_tgl),
    .q_o    (done_tgl_s)
  );

  lbk_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk_i      (rd_clk_i),
    .rst_ni     (rd_rst_ni),
    .full_tgl_i (full_tgl_s),
    .len_i      (len),
    .rdata_i    (rdata),
    .raddr_o    (raddr),
    .done_tgl_o (done_tgl),
    .dv_o       (rd_dv_o),
    .data_o     (rd_data_o)
  );
endmodule

// File: tb/lbk_bridge_test.sv
`timescale 1ns/1ps
module lbk_bridge_test;
  localparam int DEPTH = 64;
  localparam real WR_HALF = 2.0;
  localparam real RD_HALF = 2.2;

  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst_n = 0, rd_rst_n = 0;
  logic wr_dv = 0;
  logic [3:0] wr_data = 0;
  logic wr_ovf, rd_dv;
  logic [3:0] rd_data;

  always #(WR_HALF) wr_clk = ~wr_clk;
  always #(RD_HALF) rd_clk = ~rd_clk;

  lbk_bridge #(.DEPTH(DEPTH)) uut (
    .wr_clk_i (wr_clk), .wr_rst_ni (wr_rst_n), .wr_dv_i (wr_dv),
    .wr_data_i (wr_data), .wr_ovf_o (wr_ovf),
    .rd_clk_i (rd_clk), .rd_rst_ni (rd_rst_n),
    .rd_dv_o (rd_dv), .rd_data_o (rd_data)
  );

  int checks = 0, errors = 0;
  int frames_done = 0;
  bit in_run = 0;
  realtime t_first_dv = 0, t_wr_end = 0;
  logic [3:0] cur[$];
  logic [3:0] last[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pat(input int seed, input int i);
    return 4'((seed + 3 * i) % 16);
  endfunction

  // Collect replayed bursts away from the read clock's active edge
  initial forever begin
    @(negedge rd_clk);
    if (rd_dv) begin
      if (!in_run) t_first_dv = $realtime;
      in_run = 1;
      cur.push_back(rd_data);
    end else if (in_run) begin
      in_run = 0;
      last = cur;
      cur.delete();
      frames_done++;
    end
  end

  task automatic send(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_dv = 1;
      wr_data = pat(seed, i);
    end
    @(negedge wr_clk);
    wr_dv = 0;
    t_wr_end = $realtime;
  endtask

  task automatic wait_frames(input int n);
    for (int i = 0; i < 3000 && frames_done < n; i++) @(negedge rd_clk);
  endtask

  task automatic check_last(input string req, input int n, input int seed);
    int bad = 0;
    chk(last.size() == n, req, last.size(), n);
    for (int i = 0; i < n && i < last.size(); i++)
      if (last[i] !== pat(seed, i)) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset;
    repeat (20) @(negedge rd_clk);
    chk(rd_dv == 0, "R1 rd_dv", rd_dv, 0);
    chk(wr_ovf == 0, "R1 ovf", wr_ovf, 0);
    chk(frames_done == 0, "R1 no replay", frames_done, 0);
  endtask

  task automatic t_basic;
    int n0 = frames_done;
    send(10, 3);
    wait_frames(n0 + 1);
    chk(frames_done == n0 + 1, "R2 frame count", frames_done, n0 + 1);
    check_last("R2 content", 10, 3);
    chk(wr_ovf == 0, "R6 no ovf", wr_ovf, 0);
    repeat (20) @(negedge wr_clk);
    send(1, 11);
    wait_frames(n0 + 2);
    check_last("R2 single nibble", 1, 11);
  endtask

  task automatic t_drop;
    int n0;
    realtime t_a;
    repeat (20) @(negedge wr_clk);
    n0 = frames_done;
    send(20, 5);
    t_a = t_wr_end;
    repeat (2) @(negedge wr_clk);
    send(6, 9);
    wait_frames(n0 + 1);
    check_last("R3 first kept", 20, 5);
    // R4: burst start lags frame end by at least two read periods
    chk((t_first_dv - t_a) >= 4.0 * RD_HALF, "R4 start delay",
        int'((t_first_dv - t_a) * 10.0), int'(40.0 * RD_HALF));
    repeat (200) @(negedge rd_clk);
    chk(frames_done == n0 + 1, "R3 second dropped", frames_done, n0 + 1);
  endtask

  task automatic t_release;
    int n0 = frames_done;
    repeat (10) @(negedge wr_clk);
    send(8, 2);
    wait_frames(n0 + 1);
    chk(frames_done == n0 + 1, "R5 accepted", frames_done, n0 + 1);
    check_last("R5 content", 8, 2);
  endtask

  task automatic t_overflow;
    int n0 = frames_done;
    repeat (10) @(negedge wr_clk);
    send(DEPTH + 7, 6);
    wait_frames(n0 + 1);
    check_last("R6 truncated", DEPTH, 6);
    chk(wr_ovf == 1, "R6 ovf set", wr_ovf, 1);
    repeat (10) @(negedge wr_clk);
    send(4, 1);
    chk(wr_ovf == 0, "R6 ovf cleared", wr_ovf, 0);
    wait_frames(n0 + 2);
    check_last("R6 next frame", 4, 1);
  endtask

  task automatic t_idle;
    int n0 = frames_done;
    int hi = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge rd_clk);
      if (rd_dv) hi++;
    end
    chk(hi == 0, "R7 idle low", hi, 0);
    chk(frames_done == n0, "R7 no burst", frames_done, n0);
  endtask

  initial begin
    #200000ns;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge wr_clk);
    wr_rst_n = 1;
    rd_rst_n = 1;
    t_reset();
    t_basic();
    t_drop();
    t_release();
    t_overflow();
    t_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule